// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block derives the serial-clock timing of an I2C master from the system clock. It divides the clock in two stages. The first stage is a power-of-two predivider that a 2-bit mode field selects. The second stage is an 8-bit programmable count, which an optional filter setting lengthens. The bit engine that drives SCL and SDA consumes three single-cycle strobes: one at the end of each bit period, one at the boundary between the low and high halves, and one in the middle of each half.

Software picks the mode, divider and filter values for the bus speed it needs; the generator does not search for a best setting. The block counts only while its enable input is high. Dropping enable silences every strobe at once and clears the counters, so each new run begins with a complete low half. New settings are taken only at a period boundary, so a bit in flight is never stretched or cut short.

Top module: `i2c_rate_gen`

## Requirements
- R1: The predivide factor P is 2^(5 − pre_mode): 32 for mode 0, 16 for mode 1, 8 for mode 2 and 4 for mode 3.
- R2: With N = div_val + 3 + 2·filter_en, bit_tick pulses for one cycle every P·2·N system clocks, for any div_val from 0 to 255.
- R3: Setting filter_en makes the period longer by exactly 4·P system clocks, compared with the same mode and divider with filter_en clear.
- R4: Counting from the first enabled cycle as position 0 of a period, half_tick pulses at position N·P − 1 and bit_tick at position 2·N·P − 1. The first period after enable therefore opens with a full low half.
- R5: With Q = floor(N/2), quarter_tick pulses at positions Q·P − 1 and (N+Q)·P − 1 of every period, and at no other position.
- R6: No two of bit_tick, half_tick and quarter_tick are high in the same cycle.
- R7: While enable is low, all three strobes are low. Raising enable again restarts the count at position 0, whatever position was reached before.
- R8: A change to pre_mode, div_val or filter_en made in the middle of a period leaves the current period's timing unchanged. It applies from the period that starts after the next bit_tick.
- R9: While rst_n is low, all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider chain while high |
| pre_mode | input | 2 | Predivider select, factor 2^(5 − value) |
| div_val | input | 8 | Programmable divider value |
| filter_en | input | 1 | Adds 2 to the inner divide term |
| bit_tick | output | 1 | End of an SCL bit period |
| half_tick | output | 1 | End of the low half of a period |
| quarter_tick | output | 1 | Middle of the low half and middle of the high half |

## Verification
The case that is hardest to reach from the ports is a settings change that arrives in the middle of a period. That change must stay invisible until the next bit boundary. The stimulus sets new mode and divider values well inside the first period, and the bench's reference tracker adopts them only when its own period position wraps. Any early reload therefore shifts a strobe against the expected position. Restart after a mid-period disable is reached in a similar way: enable is dropped partway through a period, and the next run must still open with a complete low half.

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int DIV_W   = 8,
  parameter int PRE_LOG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       pre_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             filter_en,
  output logic             bit_tick,
  output logic             half_tick,
  output logic             quarter_tick
);

  localparam int N_W  = DIV_W + 1;
  localparam int QC_W = N_W + 1;
  localparam int PC_W = PRE_LOG;

  logic             run_q;
  logic [1:0]       mode_q, eff_mode;
  logic [N_W-1:0]   n_q, n_in, eff_n, q_len;
  logic [PC_W-1:0]  pc, pc_last;
  logic [QC_W-1:0]  qc, per_last, half_last, q1_last, q2_last;
  logic             pre_hit, end_per;

  assign n_in     = N_W'(div_val) + N_W'(3) + (filter_en ? N_W'(2) : N_W'(0));
  assign eff_mode = run_q ? mode_q : pre_mode;
  assign eff_n    = run_q ? n_q : n_in;
  assign pc_last  = PC_W'((1 << (PRE_LOG - int'(eff_mode))) - 1);
  assign q_len    = eff_n >> 1;

  assign per_last  = {eff_n, 1'b0} - QC_W'(1);
  assign half_last = QC_W'(eff_n) - QC_W'(1);
  assign q1_last   = QC_W'(q_len) - QC_W'(1);
  assign q2_last   = QC_W'(eff_n) + QC_W'(q_len) - QC_W'(1);

  assign pre_hit = enable && (pc == pc_last);
  assign end_per = pre_hit && (qc == per_last);

  assign bit_tick     = end_per;
  assign half_tick    = pre_hit && (qc == half_last);
  assign quarter_tick = pre_hit && ((qc == q1_last) || (qc == q2_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      n_q    <= '0;
      pc     <= '0;
      qc     <= '0;
    end else begin
      run_q <= enable;
      if (!enable) begin
        pc <= '0;
        qc <= '0;
      end else begin
        if (end_per) begin
          mode_q <= pre_mode;
          n_q    <= n_in;
        end else begin
          mode_q <= eff_mode;
          n_q    <= eff_n;
        end
        if (pre_hit) begin
          pc <= '0;
          qc <= end_per ? '0 : qc + QC_W'(1);
        end else begin
          pc <= pc + PC_W'(1);
        end
      end
    end
  end

  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_tick, half_tick, quarter_tick}));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (pc == '0 && qc == '0));

  p_prediv_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pre_hit) |=> (!enable || $stable(qc)));

  p_hold_settings_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && !end_per) |=> ($stable(n_q) && $stable(mode_q)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> (qc == '0 && pc == '0));

  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable) |-> (qc <= per_last));

  p_reset_quiet_r9: assert final (rst_n || !(bit_tick || half_tick || quarter_tick));

endmodule

// File: tb/i2c_rate_gen_tb.sv
module i2c_rate_gen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       enable;
  logic [1:0] pre_mode;
  logic [7:0] div_val;
  logic       filter_en;
  logic       bit_tick, half_tick, quarter_tick;

  i2c_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_mode(pre_mode),
    .div_val(div_val), .filter_en(filter_en), .bit_tick(bit_tick),
    .half_tick(half_tick), .quarter_tick(quarter_tick)
  );

  int  n_vec = 0;
  int  n_bad = 0;
  int  m_p, m_n, pos;
  bit  done = 1'b0;

  task automatic check1(string req, string nm, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (pos %0d P=%0d N=%0d)",
               req, nm, got, exp, pos, m_p, m_n);
    end
  endtask

  task automatic load_model();
    m_p = 1 << (5 - int'(pre_mode));
    m_n = int'(div_val) + 3 + (filter_en ? 2 : 0);
    pos = 0;
  endtask

  task automatic start(int md, int dv, int fl);
    @(negedge clk);
    enable    = 1'b0;
    pre_mode  = 2'(md);
    div_val   = 8'(dv);
    filter_en = fl[0];
    @(negedge clk);
    enable = 1'b1;
    load_model();
  endtask

  // R1 R3 covered through P and the filter term in the model
  task automatic run(int cycles, int chg_at, int chg_div, int chg_mode);
    for (int j = 0; j < cycles; j++) begin
      int per, q;
      if (j == chg_at) begin
        div_val  = 8'(chg_div);
        pre_mode = 2'(chg_mode);
      end
      per = 2 * m_n * m_p;
      q   = m_n / 2;
      check1("R2", "bit_tick", bit_tick, pos == per - 1);
      check1("R4", "half_tick", half_tick, pos == m_n * m_p - 1);
      check1("R5", "quarter_tick", quarter_tick,
             (pos == q * m_p - 1) || (pos == (m_n + q) * m_p - 1));
      check1("R6", "exclusive", 1'(int'(bit_tick) + int'(half_tick) + int'(quarter_tick) > 1), 1'b0);
      pos++;
      if (pos == per) begin
        int keep;
        keep = 0;
        load_model();
        pos = keep;
      end
      @(negedge clk);
    end
  endtask

  task automatic quiet(int cycles);
    enable = 1'b0;
    for (int j = 0; j < cycles; j++) begin
      check1("R7", "bit_tick", bit_tick, 1'b0);
      check1("R7", "half_tick", half_tick, 1'b0);
      check1("R7", "quarter_tick", quarter_tick, 1'b0);
      div_val = 8'($urandom_range(0, 255));
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int divs[3];
    void'($urandom(32'd2718));
    divs[0] = 0; divs[1] = 1; divs[2] = 255;
    rst_n = 1'b0; enable = 1'b0; pre_mode = 2'd0; div_val = 8'd0; filter_en = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check1("R9", "bit_tick", bit_tick, 1'b0);
      check1("R9", "half_tick", half_tick, 1'b0);
      check1("R9", "quarter_tick", quarter_tick, 1'b0);
    end
    rst_n = 1'b1;

    // R1 R3: every mode, divider corners, both filter settings
    for (int md = 0; md < 4; md++)
      for (int di = 0; di < 3; di++)
        for (int fl = 0; fl < 2; fl++) begin
          int per, np;
          start(md, divs[di], fl);
          np  = m_n * m_p;
          per = 2 * np;
          run((np < 2000) ? 3 * per : per + np + 4, -1, 0, 0);
        end

    // R8: settings changed mid-period apply only after the boundary
    start(2, 5, 0);
    run(128 + 2 * 184, 40, 20, 3);
    start(1, 9, 1);
    run(3 * 2 * 14 * 16, 100, 2, 0);

    // R7: disable mid-period, then restart with a full low half
    start(3, 12, 0);
    run(57, -1, 0, 0);
    quiet(16);
    start(3, 12, 0);
    run(3 * 2 * 15 * 4, -1, 0, 0);
    start(0, 2, 1);
    run(333, -1, 0, 0);
    quiet(5);
    start(0, 2, 1);
    run(2 * 2 * 7 * 32, -1, 0, 0);

    // random settings with mid-period changes
    for (int k = 0; k < 10; k++) begin
      int md, dv, fl, per;
      md = int'($urandom_range(0, 3));
      dv = int'($urandom_range(0, 15));
      fl = int'($urandom_range(0, 1));
      start(md, dv, fl);
      per = 2 * m_n * m_p;
      run(2 * per + 40, int'($urandom_range(1, per - 1)),
          int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule